// File: doc/BRIEF.md
# Paged Command Register File

This block is the register back end of a paged power-management slave. A serial front end, which is outside this block, decodes the bus and hands over complete write transactions as a byte count plus up to five bytes, together with the page currently selected and single-cycle read requests. The first byte of every non-empty write is the command code. The code is kept, and a later read returns the data of that command for the page presented with the read.

Registers are banked by page. Each command exists only inside a fixed window of pages. Pages 0 to 11 carry sequencing and margining settings. Pages 0 to 15 carry monitoring settings. Pages 16 to 20 carry temperature settings, and for those the bank entry is the page minus 16. Page 255 stands for all pages at once. An access that falls outside its window changes nothing and reads back 0xFF with the acknowledge low. Writing one of the read-only commands does not store anything. Instead it records a communication fault in that page's status registers. The commands for non-volatile store and restore are accepted and do nothing.

Top module: `paged_regfile`

## Requirements
- R1: A write of one byte or more latches byte 0 into `cmd_code`, visible in the cycle after the write. A write of exactly one byte changes no register.
- R2: A write with `wr_len` = 0 pulses `wr_err` high for one cycle, in the cycle after the write. It leaves `cmd_code` and every register unchanged.
- R3: One cycle after `rd_en`, `rd_valid` is 1. A read inside its window then gives `rd_ack` = 1 and the value zero-extended to 32 bits. Any other read gives `rd_ack` = 0 and `rd_data` = 0x000000FF.
- R4: Write data is little-endian. Byte 1 is the least significant byte. A command takes 1, 2 or 4 data bytes according to its width. A write that brings fewer data bytes than that width changes nothing.
- R5: Turn-on delay (0x60, 16 bits), turn-on fault limit (0x62, 16 bits) and sequence configuration (0xE8, 32 bits) exist only on pages 0 to 11.
- R6: Power-good threshold (0x5E, 16 bits), over-voltage limit (0x40, 16 bits), channel configuration (0xE4, 16 bits), fault response (0xD9, 32 bits) and average current (0xE2, read-only, reads 0) exist only on pages 0 to 15.
- R7: Over-temperature limit (0x4F, 16 bits), temperature configuration (0xF0, 16 bits) and temperature peak (0xD6, 16 bits) are written only on pages 16 to 20, into bank entry page minus 16. A read of 0xD6 from any other page is acknowledged and returns the entry for page 16.
- R8: A write of at least two bytes to 0xDC, 0xE0 or 0xE2 on a page from 0 to 20 sets bit 1 of that page's status word (0x79, 16 bits) and bit 6 of its communication status (0x7E, 8 bits). Both bits stay set until reset. On any other page such a write has no effect.
- R9: The firmware revision command 0xE0 answers only on page 255, and it returns 1. The fault log 0xDC reads 0 on every page.
- R10: The store-all (0x15), restore-all (0x16) and store-single (0xFC) commands are accepted as writes and change no register.
- R11: After reset the values are: operation 0x80, capability 0x20, output-voltage mode 0x40, revision 0x11, over-voltage and over-temperature limits 0x7FFF, turn-on fault limit 0xFFFF, channel configuration 0x20. Every other register reads 0, and `cmd_code` is 0.
- R12: Operation (0x01, 8 bits, writable), capability (0x19), output-voltage mode (0x20), revision (0x98) and both status registers exist on pages 0 to 20. Pages 21 to 254 are reserved and acknowledge none of them.
- R13: Any command code not listed above is not acknowledged on a read and has no effect on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page | input | 8 | Page selected for the current access |
| wr_en | input | 1 | One complete write transaction this cycle |
| wr_len | input | 3 | Number of bytes in the write, command code included |
| wr_bytes | input | 40 | Write bytes; byte k at bits 8k+7:8k, byte 0 is the command |
| rd_en | input | 1 | Read request for the latched command on `page` |
| cmd_code | output | 8 | Latched command code |
| wr_err | output | 1 | Empty-write error pulse |
| rd_valid | output | 1 | Read result valid |
| rd_ack | output | 1 | Read was served |
| rd_data | output | 32 | Read data, 0xFF when not served |

## Verification
The bench goes after the edges of each page window: pages 11 and 12, 15 and 16, 20 and 21, and 255. A decoder that is off by one at any of these edges would acknowledge a page it should refuse, or refuse one it should serve. It also reads the temperature peak from pages outside the temperature window. A design that indexed those reads with the raw page would return garbage, and one that refused them would return 0xFF. Short and one-byte writes check that partial data never reaches a register. Writes to the read-only commands check that the fault bits are set on the right page and only on a valid page. A design that dropped these writes silently would leave the status registers at zero.

// File: rtl/paged_regfile.sv
module paged_regfile #(
  parameter int NSEQ  = 12,
  parameter int NMON  = 16,
  parameter int NTEMP = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  page,
  input  logic        wr_en,
  input  logic [2:0]  wr_len,
  input  logic [39:0] wr_bytes,
  input  logic        rd_en,
  output logic [7:0]  cmd_code,
  output logic        wr_err,
  output logic        rd_valid,
  output logic        rd_ack,
  output logic [31:0] rd_data
);
  localparam int NPAGE = NMON + NTEMP;
  localparam int SW = $clog2(NSEQ);
  localparam int MW = $clog2(NMON);
  localparam int TW = $clog2(NTEMP);
  localparam int PW = $clog2(NPAGE);

  localparam logic [7:0] C_OPER = 8'h01, C_CAP = 8'h19, C_VMODE = 8'h20, C_OVL = 8'h40;
  localparam logic [7:0] C_OTL = 8'h4F, C_PGON = 8'h5E, C_TON = 8'h60, C_TONL = 8'h62;
  localparam logic [7:0] C_STW = 8'h79, C_STC = 8'h7E, C_REV = 8'h98, C_FRESP = 8'hD9;
  localparam logic [7:0] C_TPK = 8'hD6, C_FLOG = 8'hDC, C_FWREV = 8'hE0, C_IAVG = 8'hE2;
  localparam logic [7:0] C_CHCFG = 8'hE4, C_SEQC = 8'hE8, C_TCFG = 8'hF0;

  logic [7:0]  oper [NPAGE];
  logic [15:0] stw  [NPAGE];
  logic [7:0]  stc  [NPAGE];
  logic [15:0] ovl [NMON], pgon [NMON], chcfg [NMON];
  logic [31:0] fresp [NMON];
  logic [15:0] ton [NSEQ], tonl [NSEQ];
  logic [31:0] seqc [NSEQ];
  logic [15:0] otl [NTEMP], tpk [NTEMP], tcfg [NTEMP];

  wire in_seq = page < 8'(NSEQ);
  wire in_mon = page < 8'(NMON);
  wire in_pg  = page < 8'(NPAGE);
  wire in_tmp = (page >= 8'(NMON)) && in_pg;
  wire [SW-1:0] si = page[SW-1:0];
  wire [MW-1:0] mi = page[MW-1:0];
  wire [PW-1:0] pi = page[PW-1:0];
  wire [TW-1:0] ti = TW'(page - 8'(NMON));

  wire [7:0]  cw  = wr_bytes[7:0];
  wire [7:0]  w8  = wr_bytes[15:8];
  wire [15:0] w16 = wr_bytes[23:8];
  wire [31:0] w32 = wr_bytes[39:8];
  wire has1 = wr_len >= 3'd2;
  wire has2 = wr_len >= 3'd3;
  wire has4 = wr_len >= 3'd5;

  logic        rhit;
  logic [31:0] rval;

  always_comb begin
    rhit = 1'b0;
    rval = '0;
    case (cmd_code)
      C_OPER:  begin rhit = in_pg;  rval = 32'(oper[pi]); end
      C_CAP:   begin rhit = in_pg;  rval = 32'h20; end
      C_VMODE: begin rhit = in_pg;  rval = 32'h40; end
      C_REV:   begin rhit = in_pg;  rval = 32'h11; end
      C_STW:   begin rhit = in_pg;  rval = 32'(stw[pi]); end
      C_STC:   begin rhit = in_pg;  rval = 32'(stc[pi]); end
      C_OVL:   begin rhit = in_mon; rval = 32'(ovl[mi]); end
      C_PGON:  begin rhit = in_mon; rval = 32'(pgon[mi]); end
      C_CHCFG: begin rhit = in_mon; rval = 32'(chcfg[mi]); end
      C_FRESP: begin rhit = in_mon; rval = fresp[mi]; end
      C_IAVG:  begin rhit = in_mon; rval = '0; end
      C_TON:   begin rhit = in_seq; rval = 32'(ton[si]); end
      C_TONL:  begin rhit = in_seq; rval = 32'(tonl[si]); end
      C_SEQC:  begin rhit = in_seq; rval = seqc[si]; end
      C_OTL:   begin rhit = in_tmp; rval = 32'(otl[ti]); end
      C_TCFG:  begin rhit = in_tmp; rval = 32'(tcfg[ti]); end
      C_TPK:   begin rhit = 1'b1;   rval = 32'(in_tmp ? tpk[ti] : tpk[0]); end
      C_FLOG:  begin rhit = 1'b1;   rval = '0; end
      C_FWREV: begin rhit = page == 8'hFF; rval = 32'd1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGE; i++) begin
        oper[i] <= 8'h80; stw[i] <= '0; stc[i] <= '0;
      end
      for (int i = 0; i < NMON; i++) begin
        ovl[i] <= 16'h7FFF; pgon[i] <= '0; chcfg[i] <= 16'h0020; fresp[i] <= '0;
      end
      for (int i = 0; i < NSEQ; i++) begin
        ton[i] <= '0; tonl[i] <= 16'hFFFF; seqc[i] <= '0;
      end
      for (int i = 0; i < NTEMP; i++) begin
        otl[i] <= 16'h7FFF; tpk[i] <= '0; tcfg[i] <= '0;
      end
      cmd_code <= '0;
      wr_err   <= 1'b0;
      rd_valid <= 1'b0;
      rd_ack   <= 1'b0;
      rd_data  <= 32'hFF;
    end else begin
      wr_err   <= wr_en && (wr_len == 3'd0);
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_ack  <= rhit;
        rd_data <= rhit ? rval : 32'hFF;
      end
      if (wr_en && wr_len != 3'd0) cmd_code <= cw;
      if (wr_en && has1) begin
        case (cw)
          C_OPER:  if (in_pg) oper[pi] <= w8;
          C_OVL:   if (in_mon && has2) ovl[mi] <= w16;
          C_PGON:  if (in_mon && has2) pgon[mi] <= w16;
          C_CHCFG: if (in_mon && has2) chcfg[mi] <= w16;
          C_FRESP: if (in_mon && has4) fresp[mi] <= w32;
          C_TON:   if (in_seq && has2) ton[si] <= w16;
          C_TONL:  if (in_seq && has2) tonl[si] <= w16;
          C_SEQC:  if (in_seq && has4) seqc[si] <= w32;
          C_OTL:   if (in_tmp && has2) otl[ti] <= w16;
          C_TCFG:  if (in_tmp && has2) tcfg[ti] <= w16;
          C_TPK:   if (in_tmp && has2) tpk[ti] <= w16;
          C_FLOG, C_FWREV, C_IAVG:
            if (in_pg) begin
              stw[pi] <= stw[pi] | 16'h0002;
              stc[pi] <= stc[pi] | 8'h40;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

module paged_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_len,
  input logic        rd_en,
  input logic [7:0]  cmd_code,
  input logic        wr_err,
  input logic        rd_valid,
  input logic        rd_ack,
  input logic [31:0] rd_data
);
  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en && wr_len == 3'd0));
  // R2
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_len == 3'd0) |=> wr_err);
  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_len != 3'd0) |=> $stable(cmd_code));
  // R3
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R3
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  // R3
  miss_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ack) |-> rd_data == 32'hFF);
endmodule

bind paged_regfile paged_regfile_chk u_chk (.*);

// File: tb/paged_regfile_bench.sv
module paged_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  page = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_len = '0;
  logic [39:0] wr_bytes = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  cmd_code;
  logic        wr_err, rd_valid, rd_ack;
  logic [31:0] rd_data;

  paged_regfile u_paged_regfile (.*);

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  logic [31:0] m [13][21];
  logic [7:0]  mcmd;

  localparam logic [7:0] CL [26] = '{8'h01, 8'h19, 8'h20, 8'h40, 8'h4F, 8'h5E, 8'h60, 8'h62,
    8'h79, 8'h7E, 8'h98, 8'hD9, 8'hD6, 8'hDC, 8'hE0, 8'hE2, 8'hE4, 8'hE8, 8'hF0,
    8'h15, 8'h16, 8'hFC, 8'h00, 8'h55, 8'hD4, 8'hFF};

  function automatic int slot(logic [7:0] c);
    case (c)
      8'h01: return 0;  8'h40: return 1;  8'h4F: return 2;  8'h5E: return 3;
      8'h60: return 4;  8'h62: return 5;  8'h79: return 6;  8'h7E: return 7;
      8'hD9: return 8;  8'hD6: return 9;  8'hE4: return 10; 8'hE8: return 11;
      8'hF0: return 12; default: return 0;
    endcase
  endfunction

  function automatic int wid(logic [7:0] c);
    case (c)
      8'h01: return 1;
      8'h40, 8'h4F, 8'h5E, 8'h60, 8'h62, 8'hE4, 8'hD6, 8'hF0: return 2;
      8'hD9, 8'hE8: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit rv(logic [7:0] c, logic [7:0] p);
    case (c)
      8'h01, 8'h19, 8'h20, 8'h98, 8'h79, 8'h7E: return p < 21;
      8'h60, 8'h62, 8'hE8: return p < 12;
      8'h40, 8'h5E, 8'hE4, 8'hD9, 8'hE2: return p < 16;
      8'h4F, 8'hF0: return p >= 16 && p < 21;
      8'hD6, 8'hDC: return 1'b1;
      8'hE0: return p == 8'hFF;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] c);
    case (c)
      8'h60, 8'h62, 8'hE8: return "R5";
      8'h40, 8'h5E, 8'hE4, 8'hD9, 8'hE2: return "R6";
      8'h4F, 8'hF0, 8'hD6: return "R7";
      8'hDC, 8'h79, 8'h7E: return "R8";
      8'hE0: return "R9";
      8'h15, 8'h16, 8'hFC: return "R10";
      8'h01, 8'h19, 8'h20, 8'h98: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [32:0] exp_rd(logic [7:0] c, logic [7:0] p);
    if (!rv(c, p)) return {1'b0, 32'hFF};
    case (c)
      8'h19: return {1'b1, 32'h20};
      8'h20: return {1'b1, 32'h40};
      8'h98: return {1'b1, 32'h11};
      8'hDC, 8'hE2: return {1'b1, 32'h0};
      8'hE0: return {1'b1, 32'h1};
      8'hD6: return {1'b1, (p >= 16 && p < 21) ? m[9][p] : m[9][16]};
      default: return {1'b1, m[slot(c)][p]};
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 13; s++)
      for (int p = 0; p < 21; p++) m[s][p] = '0;
    for (int p = 0; p < 21; p++) m[0][p] = 32'h80;
    for (int p = 0; p < 16; p++) begin m[1][p] = 32'h7FFF; m[10][p] = 32'h20; end
    for (int p = 0; p < 12; p++) m[5][p] = 32'hFFFF;
    for (int p = 16; p < 21; p++) m[2][p] = 32'h7FFF;
    mcmd = '0;
  endtask

  task automatic wr(int len, logic [39:0] b, logic [7:0] p, string req);
    logic [7:0] c;
    logic [31:0] d;
    int w;
    @(negedge clk);
    page = p; wr_en = 1'b1; wr_len = 3'(len); wr_bytes = b;
    @(negedge clk);
    wr_en = 1'b0;
    c = b[7:0];
    w = wid(c);
    if (len >= 1) mcmd = c;
    if (len >= 2) begin
      if ((c == 8'hDC || c == 8'hE0 || c == 8'hE2) && p < 21) begin
        m[6][p] = m[6][p] | 32'h2;
        m[7][p] = m[7][p] | 32'h40;
      end else if (w != 0 && len >= 1 + w &&
                   (c == 8'hD6 ? (p >= 16 && p < 21) : rv(c, p))) begin
        d = b[39:8];
        if (w == 1) d = d & 32'hFF;
        else if (w == 2) d = d & 32'hFFFF;
        m[slot(c)][p] = d;
      end
    end
    chk((len == 0) ? "R2" : "R1", {55'd0, wr_err, cmd_code}, {55'd0, (len == 0), mcmd});
  endtask

  task automatic rd(logic [7:0] p, string req);
    @(negedge clk);
    page = p; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {30'd0, rd_valid, rd_ack, rd_data}, {30'd0, 1'b1, exp_rd(mcmd, p)});
  endtask

  task automatic rdc(logic [7:0] c, logic [7:0] p, string req);
    wr(1, {32'd0, c}, p, "R1");
    rd(p, req);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R3 watchdog expired actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11", {55'd0, rd_valid, cmd_code}, 64'd0);
    // R11 defaults
    rdc(8'h01, 8'd3, "R11");  rdc(8'h19, 8'd0, "R11");  rdc(8'h20, 8'd20, "R11");
    rdc(8'h98, 8'd7, "R11");  rdc(8'h40, 8'd15, "R11"); rdc(8'h4F, 8'd20, "R11");
    rdc(8'h62, 8'd11, "R11"); rdc(8'hE4, 8'd0, "R11");  rdc(8'h79, 8'd9, "R11");
    // R4 little-endian 32-bit, then short writes ignored
    wr(5, {32'h44332211, 8'hE8}, 8'd2, "R4");
    rdc(8'hE8, 8'd2, "R4");
    chk("R4", {32'd0, rd_data}, 64'h44332211);
    wr(3, {32'h99887766, 8'hE8}, 8'd2, "R4");
    rd(8'd2, "R4");
    wr(2, {32'h0000ABCD, 8'h60}, 8'd1, "R4");
    rdc(8'h60, 8'd1, "R4");
    // R1 one-byte write changes nothing
    wr(3, {32'h00001234, 8'h60}, 8'd11, "R5");
    wr(1, {32'h0000FFFF, 8'h60}, 8'd11, "R1");
    rd(8'd11, "R1");
    // R2 empty write
    wr(0, {32'h0000BEEF, 8'h5E}, 8'd0, "R2");
    rd(8'd11, "R2");
    // R5 window edge at page 12
    wr(3, {32'h00005555, 8'h60}, 8'd12, "R5");
    rd(8'd12, "R5"); rd(8'd11, "R5");
    // R6 window edge at page 16
    wr(3, {32'h00000AAA, 8'h5E}, 8'd15, "R6");
    rdc(8'h5E, 8'd15, "R6"); rd(8'd16, "R6");
    rdc(8'hE2, 8'd4, "R6");
    // R7 temperature peak banking
    wr(3, {32'h00000C0D, 8'hD6}, 8'd18, "R7");
    wr(3, {32'h00000B0B, 8'hD6}, 8'd16, "R7");
    rdc(8'hD6, 8'd18, "R7"); rd(8'd5, "R7"); rd(8'd200, "R7");
    wr(3, {32'h00000777, 8'hF0}, 8'd21, "R7");
    rdc(8'hF0, 8'd20, "R7"); rd(8'd21, "R7");
    // R8 read-only writes raise flags
    wr(3, {32'h00001111, 8'hE2}, 8'd4, "R8");
    rdc(8'h79, 8'd4, "R8"); chk("R8", {32'd0, rd_data}, 64'h2);
    rdc(8'h7E, 8'd4, "R8"); chk("R8", {32'd0, rd_data}, 64'h40);
    wr(2, {32'h00000022, 8'hDC}, 8'd30, "R8");
    rdc(8'h79, 8'd5, "R8");
    // R9 firmware revision
    rdc(8'hE0, 8'hFF, "R9"); chk("R9", {31'd0, rd_ack, rd_data}, {31'd0, 1'b1, 32'd1});
    rd(8'd0, "R9"); rdc(8'hDC, 8'd77, "R9");
    // R10 store and restore are no-ops
    wr(3, {32'h0000FFFF, 8'h15}, 8'd2, "R10");
    wr(5, {32'hFFFFFFFF, 8'h16}, 8'd2, "R10");
    wr(3, {32'h0000FFFF, 8'hFC}, 8'd2, "R10");
    rdc(8'hE8, 8'd2, "R10"); rdc(8'h15, 8'd2, "R10");
    // R12 reserved pages
    wr(2, {32'h00000042, 8'h01}, 8'd20, "R12");
    rdc(8'h01, 8'd20, "R12"); rd(8'd21, "R12"); rd(8'd254, "R12");
    // R13 unsupported code
    wr(3, {32'h00001234, 8'h55}, 8'd0, "R13");
    rdc(8'h55, 8'd0, "R13");
    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] c, p;
      int r, len;
      c = CL[$urandom % 26];
      r = $urandom % 10;
      if (r < 7) p = 8'($urandom % 21);
      else if (r == 7) p = 8'hFF;
      else if (r == 8) p = 8'(21 + $urandom % 234);
      else p = 8'($urandom % 256);
      if ($urandom % 2 == 0) begin
        r = $urandom % 10;
        len = (r < 4) ? r : 5;
        wr(len, {$urandom, c}, p, req_of(c));
      end else begin
        rdc(c, p, req_of(c));
      end
    end
    summary();
    $finish;
  end
endmodule